// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block is the decision core of an eight-line interrupt controller. From the current request, mask and in-service vectors it works out whether the interrupt output should be raised and, if so, which input line has won. Priority is not fixed to line numbers. A rotation offset names the line that holds the top level, and the remaining lines follow it in ascending order with wrap-around. Register storage, bus access and acknowledge sequencing sit outside the block. It is purely combinational, so its outputs follow the register state with no added latency.

A request only interrupts when it outranks everything already in service. Two controls change which in-service bits count toward that comparison. In special-mask operation, in-service bits whose lines are masked are left out. In special fully-nested operation on a primary unit, the in-service bit of the cascade line is left out. A second, independent priority finder applies the same rotation to an arbitrary vector. End-of-interrupt logic uses it to locate the highest-priority in-service line.

Top module: `rprio_resolver`

## Requirements
- R1: The candidate set is `req_vec & ~mask_vec`. A line whose mask bit is 1 never wins, and `int_valid` is 0 when every requesting line is masked.
- R2: Priority level p belongs to line (p + `rot_base`) mod 8, and level 0 is the highest. Among candidates, the line with the smallest level wins.
- R3: When the candidate set is empty, `int_valid` is 0 and `int_line` is 0.
- R4: The in-service level is the smallest level of a set bit in `isr_vec`. When `spec_mask_en` is 1, `isr_vec` bits whose `mask_vec` bit is 1 are excluded first. An empty in-service set has level 8.
- R5: When both `nest_en` and `is_primary` are 1, in-service bit 2 (the cascade line) is excluded from the in-service level. With either of the two at 0, that bit counts normally.
- R6: `int_valid` is 1 only when the winning request level is strictly lower than the in-service level. An equal level gives 0.
- R7: When `int_valid` is 1, `int_line` equals (winning level + `rot_base`) mod 8. Otherwise it is 0.
- R8: `aux_level` is the level of the highest-priority set bit of `aux_vec` under the same rotation, or 8 when `aux_vec` is 0. `aux_line` is (`aux_level` + `rot_base`) mod 8, or 0 when `aux_vec` is 0.
- R9: All outputs are combinational functions of the current inputs. They are valid within the same cycle, with no register between inputs and outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_vec | input | 8 | Pending request bits, one per line |
| mask_vec | input | 8 | Mask bits, 1 blocks the line |
| isr_vec | input | 8 | In-service bits, one per line |
| rot_base | input | 3 | Line that holds priority level 0 |
| spec_mask_en | input | 1 | Exclude masked lines from the in-service set |
| nest_en | input | 1 | Special fully-nested operation |
| is_primary | input | 1 | Unit is the primary of a cascade |
| aux_vec | input | 8 | Vector for the helper priority finder |
| int_valid | output | 1 | A request outranks the in-service set |
| int_line | output | 3 | Winning line number |
| aux_level | output | 4 | Helper: level of the top set bit, 8 if none |
| aux_line | output | 3 | Helper: line of the top set bit |

## Verification
Every result is due within the same cycle as its stimulus because no register lies on any path. The bench changes inputs on the rising edge and compares all four outputs against its behavioural model at the following falling edge, half a period later. One directed case goes further: it changes the inputs away from any edge and samples one time unit later, which shows that no clock is needed.

// File: rtl/rprio_pkg.sv
package rprio_pkg;
   localparam int unsigned RPRIO_LINES   = 8;
   localparam int unsigned RPRIO_IDX_W   = $clog2(RPRIO_LINES);
   localparam int unsigned RPRIO_CASCADE = 2;

   typedef enum logic [0:0] {
      ROT_MUX    = 1'b0,
      ROT_BARREL = 1'b1
   } rot_style_e;
endpackage

// File: rtl/rprio_rotate.sv
module rprio_rotate
   import rprio_pkg::*;
#(
   parameter int unsigned N     = 8,
   parameter rot_style_e  STYLE = ROT_BARREL,
   localparam int unsigned W    = $clog2(N)
) (
   input  logic [N-1:0] vec_in,
   input  logic [W-1:0] shift,
   output logic [N-1:0] vec_out
);
   // vec_out[p] = vec_in[(p + shift) mod N]
   generate
      if (N != (1 << W)) begin : g_bad_n
         $error("rprio_rotate: N must be a power of two");
      end
      if (STYLE == ROT_MUX) begin : g_mux
         for (genvar p = 0; p < N; p++) begin : g_lvl
            logic [W-1:0] src;
            assign src        = W'(p) + shift;
            assign vec_out[p] = vec_in[src];
         end
      end else begin : g_barrel
         logic [N-1:0] stage [W+1];
         assign stage[0] = vec_in;
         for (genvar s = 0; s < W; s++) begin : g_stage
            localparam int unsigned D = 1 << s;
            logic [N-1:0] rotd;
            for (genvar p = 0; p < N; p++) begin : g_bit
               assign rotd[p] = stage[s][(p + D) % N];
            end
            assign stage[s+1] = shift[s] ? rotd : stage[s];
         end
         assign vec_out = stage[W];
      end
   endgenerate
endmodule

// File: rtl/rprio_first.sv
module rprio_first #(
   parameter int unsigned N  = 8,
   localparam int unsigned W = $clog2(N)
) (
   input  logic [N-1:0] vec,
   output logic [W:0]   level
);
   // smallest index of a set bit; N when the vector is empty
   always_comb begin
      level = (W+1)'(N);
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) level = (W+1)'(i);
      end
   end

   always_comb begin
      // R8
      first_none_chk: assert ((vec == '0) == (level == (W+1)'(N)));
      // R2
      if (level != (W+1)'(N)) begin
         first_hit_chk: assert (vec[level[W-1:0]]);
         first_low_chk: assert ((vec & ((N'(1) << level[W-1:0]) - N'(1))) == '0);
      end
   end
endmodule

// File: rtl/rprio_ceiling.sv
module rprio_ceiling #(
   parameter int unsigned N       = 8,
   parameter int unsigned CASCADE = 2
) (
   input  logic [N-1:0] isr_vec,
   input  logic [N-1:0] mask_vec,
   input  logic         spec_mask_en,
   input  logic         nest_en,
   input  logic         is_primary,
   output logic [N-1:0] isr_eff
);
   generate
      if (CASCADE >= N) begin : g_bad_casc
         $error("rprio_ceiling: CASCADE out of range");
      end
   endgenerate

   logic [N-1:0] after_mask;
   assign after_mask = spec_mask_en ? (isr_vec & ~mask_vec) : isr_vec;

   always_comb begin
      isr_eff = after_mask;
      if (nest_en && is_primary) isr_eff[CASCADE] = 1'b0;
   end

   always_comb begin
      // R4
      ceil_subset_chk: assert ((isr_eff & ~isr_vec) == '0);
      // R5
      if (nest_en && is_primary) begin
         ceil_casc_chk: assert (!isr_eff[CASCADE]);
      end
   end
endmodule

// File: rtl/rprio_resolver.sv
module rprio_resolver
   import rprio_pkg::*;
#(
   parameter int unsigned N       = RPRIO_LINES,
   parameter int unsigned CASCADE = RPRIO_CASCADE,
   parameter rot_style_e  STYLE   = ROT_BARREL,
   localparam int unsigned W      = $clog2(N)
) (
   input  logic [N-1:0] req_vec,
   input  logic [N-1:0] mask_vec,
   input  logic [N-1:0] isr_vec,
   input  logic [W-1:0] rot_base,
   input  logic         spec_mask_en,
   input  logic         nest_en,
   input  logic         is_primary,
   input  logic [N-1:0] aux_vec,
   output logic         int_valid,
   output logic [W-1:0] int_line,
   output logic [W:0]   aux_level,
   output logic [W-1:0] aux_line
);
   localparam logic [W:0] NONE = (W+1)'(N);

   generate
      if (N < 2) begin : g_bad_small
         $error("rprio_resolver: need at least two lines");
      end
   endgenerate

   logic [N-1:0] cand, cand_rot, isr_eff, isr_rot, aux_rot;
   logic [W:0]   req_level, cur_level;

   assign cand = req_vec & ~mask_vec;

   rprio_ceiling #(.N(N), .CASCADE(CASCADE)) u_ceiling (
      .isr_vec      (isr_vec),
      .mask_vec     (mask_vec),
      .spec_mask_en (spec_mask_en),
      .nest_en      (nest_en),
      .is_primary   (is_primary),
      .isr_eff      (isr_eff)
   );

   rprio_rotate #(.N(N), .STYLE(STYLE)) u_rot_req (
      .vec_in (cand), .shift (rot_base), .vec_out (cand_rot));
   rprio_rotate #(.N(N), .STYLE(STYLE)) u_rot_isr (
      .vec_in (isr_eff), .shift (rot_base), .vec_out (isr_rot));
   rprio_rotate #(.N(N), .STYLE(STYLE)) u_rot_aux (
      .vec_in (aux_vec), .shift (rot_base), .vec_out (aux_rot));

   rprio_first #(.N(N)) u_first_req (.vec (cand_rot), .level (req_level));
   rprio_first #(.N(N)) u_first_isr (.vec (isr_rot),  .level (cur_level));
   rprio_first #(.N(N)) u_first_aux (.vec (aux_rot),  .level (aux_level));

   assign int_valid = (req_level < cur_level);
   assign int_line  = int_valid ? (req_level[W-1:0] + rot_base) : '0;
   assign aux_line  = (aux_level == NONE) ? '0 : (aux_level[W-1:0] + rot_base);

   always_comb begin
      // R3
      empty_cand_chk: assert ((cand != '0) || !int_valid);
      // R1
      if (int_valid) begin
         winner_unmasked_chk: assert (req_vec[int_line] && !mask_vec[int_line]);
      end
      // R7
      if (!int_valid) begin
         idle_line_chk: assert (int_line == '0);
      end
      // R8
      if (aux_level != NONE) begin
         aux_hit_chk: assert (aux_vec[aux_line]);
      end
   end
endmodule

// File: tb/rprio_resolver_bench.sv
module rprio_resolver_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic       clk = 1'b0;
   logic [7:0] req_vec = '0, mask_vec = '0, isr_vec = '0, aux_vec = '0;
   logic [2:0] rot_base = '0;
   logic       spec_mask_en = 1'b0, nest_en = 1'b0, is_primary = 1'b0;
   logic       int_valid;
   logic [2:0] int_line, aux_line;
   logic [3:0] aux_level;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rprio_resolver u_rprio_resolver (
      .req_vec (req_vec), .mask_vec (mask_vec), .isr_vec (isr_vec),
      .rot_base (rot_base), .spec_mask_en (spec_mask_en), .nest_en (nest_en),
      .is_primary (is_primary), .aux_vec (aux_vec),
      .int_valid (int_valid), .int_line (int_line),
      .aux_level (aux_level), .aux_line (aux_line));

   function automatic int lvl_of(logic [7:0] v, int off);
      for (int p = 0; p < 8; p++) if (v[(p + off) % 8]) return p;
      return 8;
   endfunction

   task automatic chk(string tag, int act, int exp);
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // compare all outputs against the behavioural model
   task automatic compare(string tag);
      logic [7:0] cur;
      int rl, cl, al, ev, el;
      n_vec++;
      cur = isr_vec;
      if (spec_mask_en) cur = cur & ~mask_vec;
      if (nest_en && is_primary) cur[2] = 1'b0;
      rl = lvl_of(req_vec & ~mask_vec, rot_base);
      cl = lvl_of(cur, rot_base);
      al = lvl_of(aux_vec, rot_base);
      ev = (rl < cl) ? 1 : 0;
      el = ev ? (rl + rot_base) % 8 : 0;
      chk({tag, "/R6 valid"}, int_valid, ev);
      chk({tag, "/R7 line"}, int_line, el);
      chk({tag, "/R8 aux_level"}, aux_level, al);
      chk({tag, "/R8 aux_line"}, aux_line, (al == 8) ? 0 : (al + rot_base) % 8);
   endtask

   task automatic put(logic [7:0] rq, logic [7:0] mk, logic [7:0] is,
                      logic [2:0] off, logic sm, logic nf, logic pr, logic [7:0] ax);
      @(posedge clk);
      req_vec = rq; mask_vec = mk; isr_vec = is; rot_base = off;
      spec_mask_en = sm; nest_en = nf; is_primary = pr; aux_vec = ax;
      @(negedge clk);
   endtask

   initial begin
      #(WATCHDOG * CLK_PERIOD);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      // idle state: all inputs zero
      @(negedge clk);
      compare("R3 idle");
      chk("R3 idle valid", int_valid, 0);
      chk("R8 idle aux_level", aux_level, 8);

      // R1: only masked requests
      put(8'h10, 8'h10, 8'h00, 3'd0, 0, 0, 0, 8'h00);
      compare("R1"); chk("R1 masked", int_valid, 0);

      // R2: offset 3, lines 1 and 4 request -> line 4 (level 1) wins
      put(8'h12, 8'h00, 8'h00, 3'd3, 0, 0, 0, 8'h12);
      compare("R2"); chk("R2 rotated line", int_line, 4);
      chk("R8 rotated aux_line", aux_line, 4);

      // R4: in-service line 1 masked, special mask on -> line 5 allowed
      put(8'h20, 8'h02, 8'h02, 3'd0, 1, 0, 0, 8'h00);
      compare("R4"); chk("R4 spec mask on", int_valid, 1);
      put(8'h20, 8'h02, 8'h02, 3'd0, 0, 0, 0, 8'h00);
      compare("R4"); chk("R4 spec mask off", int_valid, 0);

      // R5: cascade in service, request on cascade line
      put(8'h04, 8'h00, 8'h04, 3'd0, 0, 1, 1, 8'h00);
      compare("R5"); chk("R5 primary nested", int_valid, 1);
      put(8'h04, 8'h00, 8'h04, 3'd0, 0, 1, 0, 8'h00);
      compare("R5"); chk("R5 secondary nested", int_valid, 0);

      // R6: equal level blocked, higher level passes
      put(8'h08, 8'h00, 8'h08, 3'd0, 0, 0, 0, 8'h08);
      compare("R6"); chk("R6 equal", int_valid, 0);
      put(8'h01, 8'h00, 8'h08, 3'd0, 0, 0, 0, 8'h00);
      compare("R6"); chk("R6 higher", int_valid, 1);

      // R7: wrap-around, offset 7 with line 0 requesting -> level 1
      put(8'h01, 8'h00, 8'h80, 3'd7, 0, 0, 0, 8'h80);
      compare("R7"); chk("R7 wrap blocked", int_valid, 0);
      chk("R8 wrap aux_level", aux_level, 0);

      // R9: change away from an edge, sample one time unit later
      #1 req_vec = 8'h40; mask_vec = 8'h00; isr_vec = 8'h00; rot_base = 3'd0;
      #1 chk("R9 same cycle line", int_line, 6);
      chk("R9 same cycle valid", int_valid, 1);
      n_vec++;

      // randomized sweep covering every offset
      for (int i = 0; i < 4000; i++) begin
         put($urandom, ($urandom % 3 == 0) ? 8'h00 : 8'($urandom),
             ($urandom % 2 == 0) ? 8'h00 : 8'($urandom), 3'(i % 8),
             1'($urandom), 1'($urandom), 1'($urandom), $urandom);
         compare("R2 random");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule